// File: doc/BRIEF.md
# Serial Configuration Loader

This block pushes a configuration bitstream into a downstream programmable device over a slave-serial link. A one-cycle start pulse begins a load. The block pulses the device's active-low program line and waits for the device's active-low init line to go low. It then releases program and waits for init to return high. Each time init or done fails to answer within a bounded number of system clock cycles, the load ends with a code that names the phase that stalled.

Once the device is ready, the loader takes bitstream bytes from a valid/ready byte stream. It shifts each byte out most significant bit first. Every bit is a three-step sequence: the serial clock falls, the data line takes the bit, and the serial clock rises. Each step is held for a programmable number of system cycles. Before each new byte it looks for an integrity error, which the device signals by driving init low while done is still low. When the byte count taken at start is reached, the loader holds the data line high and keeps toggling the serial clock until done rises.

Top module: `sercfg_loader`

## Requirements
- R1: After reset: busy_o=0, prog_n_o=1, cclk_o=0, din_o=1, byte_ready_o=0, finish_o=0 and status_o=7 (no result).
- R2: A start pulse in idle drives prog_n_o low. prog_n_o returns high only after init_n_i (two-flop synchronised) is seen low. No byte is requested (byte_ready_o) until init_n_i has then been seen high again.
- R3: If init_n_i is not seen low within TIMEOUT cycles of the program phase, the load ends with status_o=1.
- R4: If init_n_i is not seen high within TIMEOUT cycles after program is released, the load ends with status_o=2.
- R5: Each byte leaves MSB first as 8 bits. For each bit, cclk_o falls, then din_o takes the bit, then cclk_o rises, each step held DIV cycles, so rising edges inside a byte are 3*DIV cycles apart. din_o never changes while cclk_o stays high.
- R6: nbytes_i is sampled at start. Exactly that many bytes are accepted (byte_valid_i && byte_ready_o), and later changes of nbytes_i have no effect. A count of zero skips straight to the trailing clocks.
- R7: While waiting for a byte, init low together with done low ends the load with status_o=3. No further byte is accepted, and cclk_o stops low.
- R8: After the last byte, din_o is held high and cclk_o toggles every DIV cycles. The load ends with status_o=0 when done_i is seen high, or with status_o=4 if TIMEOUT cycles pass first.
- R9: Every load ends with a single-cycle finish_o pulse, in the cycle where busy_o is already low. status_o reads 7 while busy_o is high and keeps the result code until the next start.
- R10: A start pulse while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a load (one-cycle pulse, honoured in idle only) |
| nbytes_i | input | CNT_W | Number of bitstream bytes, sampled at start |
| byte_data_i | input | 8 | Bitstream byte |
| byte_valid_i | input | 1 | byte_data_i holds a byte |
| byte_ready_o | output | 1 | Loader accepts a byte this cycle |
| prog_n_o | output | 1 | Program line to the device, active low |
| cclk_o | output | 1 | Serial configuration clock |
| din_o | output | 1 | Serial configuration data |
| init_n_i | input | 1 | Device init status, active low, asynchronous |
| done_i | input | 1 | Device done status, asynchronous |
| busy_o | output | 1 | A load is in progress |
| finish_o | output | 1 | One-cycle pulse at the end of a load |
| status_o | output | 3 | 0 ok, 1 init-low timeout, 2 init-high timeout, 3 integrity error, 4 done timeout, 7 none |

## Verification
The embedded properties assume DIV is at least 2, so that during the trailing clocks the data line can settle high before the first rising edge. They also assume that init and done only change where a real device would drive them. The bench meets this with a reactive device model. That model answers the program line with fixed delays, drops init low only on purpose for the integrity-error case, and raises done after a chosen number of trailing clocks. Byte-valid gaps, byte values, lengths and trailing-clock counts come from a seeded random generator, and the bench bounds them so every run stays inside the timeout window unless a stall is the point of the test.

// File: rtl/sercfg_pkg.sv
// Shared types and result codes for the serial configuration loader.
// Assumes nothing beyond the 3-bit status width used at the top port.
package sercfg_pkg;

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_PROG,
        LD_REL,
        LD_FETCH,
        LD_SHIFT,
        LD_TRAIL
    } ld_state_t;

    typedef enum logic [1:0] {
        SH_OFF,
        SH_BYTES,
        SH_TRAIL
    } sh_mode_t;

    localparam logic [2:0] RES_OK          = 3'd0;
    localparam logic [2:0] RES_INIT_LO_TMO = 3'd1;
    localparam logic [2:0] RES_INIT_HI_TMO = 3'd2;
    localparam logic [2:0] RES_CRC         = 3'd3;
    localparam logic [2:0] RES_DONE_TMO    = 3'd4;
    localparam logic [2:0] RES_NONE        = 3'd7;

endpackage

// File: rtl/sercfg_sync.sv
// Two-flop synchroniser for asynchronous status inputs.
// Assumes each bit is an independent level; RST_VAL gives the idle level.
module sercfg_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two register stages toward the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/sercfg_timer.sv
// Saturating phase timer: counts run cycles up to LIMIT and flags expiry.
// Assumes the owner pulses clr_i whenever a new timed phase begins.
module sercfg_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic expired_o
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Count run cycles, saturating at LIMIT
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q != CW'(LIMIT))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == CW'(LIMIT));

    // a cleared timer cannot report expiry in the next cycle
    a_r3_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !expired_o);

endmodule

// File: rtl/sercfg_shifter.sv
// Serial bit engine: sends bytes MSB first as fall/data/rise steps of DIV
// cycles each, or free-runs the clock with data high in trailing mode.
// Assumes DIV >= 2 when trailing mode follows a byte ending in a zero bit.
module sercfg_shifter
    import sercfg_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  sh_mode_t mode_i,
    input  logic     load_i,
    input  logic [7:0] data_i,
    output logic     cclk_o,
    output logic     din_o,
    output logic     busy_o,
    output logic     ack_o
);

    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_q;
    logic [1:0]    phase_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic          cclk_q;
    logic          din_q;
    logic          busy_q;
    logic          ack_q;
    logic          tick;

    assign tick = (div_q == DW'(DIV - 1));

    // Step sequencer for bytes and trailing clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= '0;
            phase_q <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            cclk_q  <= 1'b0;
            din_q   <= 1'b1;
            busy_q  <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            case (mode_i)
                SH_BYTES: begin
                    if (!busy_q) begin
                        div_q <= '0;
                        if (load_i) begin
                            sh_q    <= data_i;
                            busy_q  <= 1'b1;
                            phase_q <= 2'd0;
                            bit_q   <= '0;
                            cclk_q  <= 1'b0;
                        end
                    end else if (!tick) begin
                        div_q <= div_q + 1'b1;
                    end else begin
                        div_q <= '0;
                        case (phase_q)
                            2'd0: begin
                                din_q   <= sh_q[7];
                                phase_q <= 2'd1;
                            end
                            2'd1: begin
                                cclk_q  <= 1'b1;
                                phase_q <= 2'd2;
                            end
                            default: begin
                                if (bit_q == 3'd7) begin
                                    busy_q <= 1'b0;
                                    ack_q  <= 1'b1;
                                end else begin
                                    bit_q   <= bit_q + 1'b1;
                                    sh_q    <= {sh_q[6:0], 1'b0};
                                    phase_q <= 2'd0;
                                    cclk_q  <= 1'b0;
                                end
                            end
                        endcase
                    end
                end
                SH_TRAIL: begin
                    busy_q <= 1'b0;
                    if (!cclk_q && (div_q == '0)) begin
                        din_q <= 1'b1;
                    end
                    if (!tick) begin
                        div_q <= div_q + 1'b1;
                    end else begin
                        div_q  <= '0;
                        cclk_q <= ~cclk_q;
                    end
                end
                default: begin
                    div_q   <= '0;
                    phase_q <= '0;
                    bit_q   <= '0;
                    cclk_q  <= 1'b0;
                    din_q   <= 1'b1;
                    busy_q  <= 1'b0;
                end
            endcase
        end
    end

    assign cclk_o = cclk_q;
    assign din_o  = din_q;
    assign busy_o = busy_q;
    assign ack_o  = ack_q;

    // data may only move while the serial clock is low
    a_r5_din_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cclk_o && $past(cclk_o)) |-> $stable(din_o));

    // a byte always ends on a raised serial clock
    a_r5_ack_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> cclk_o);

    // trailing rising edges carry a high data line
    a_r8_trail_din_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cclk_o) && (mode_i == SH_TRAIL)) |-> din_o);

endmodule

// File: rtl/sercfg_loader.sv
// Slave-serial configuration loader: program/init handshake with timeouts,
// byte intake from a valid/ready stream, integrity check before each byte,
// trailing clocks until done, and a coded result with a finish pulse.
// Assumes init_n_i and done_i are asynchronous levels from the device.
module sercfg_loader
    import sercfg_pkg::*;
#(
    parameter int DIV     = 4,
    parameter int TIMEOUT = 100000,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] nbytes_i,
    input  logic [7:0]       byte_data_i,
    input  logic             byte_valid_i,
    output logic             byte_ready_o,
    output logic             prog_n_o,
    output logic             cclk_o,
    output logic             din_o,
    input  logic             init_n_i,
    input  logic             done_i,
    output logic             busy_o,
    output logic             finish_o,
    output logic [2:0]       status_o
);

    ld_state_t        state_q, state_d;
    logic [CNT_W-1:0] remain_q, remain_d;
    logic [2:0]       status_q, status_d;
    logic             finish_q, finish_d;
    logic             prog_n_q, prog_n_d;
    logic             init_n_s, done_s;
    logic             tmo, crc_err;
    logic             sh_busy, sh_ack, sh_load;
    sh_mode_t         sh_mode;

    sercfg_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({done_i, init_n_i}),
        .q_o   ({done_s, init_n_s})
    );

    sercfg_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (state_d != state_q),
        .run_i     ((state_q == LD_PROG) || (state_q == LD_REL) || (state_q == LD_TRAIL)),
        .expired_o (tmo)
    );

    sercfg_shifter #(.DIV(DIV)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (sh_mode),
        .load_i (sh_load),
        .data_i (byte_data_i),
        .cclk_o (cclk_o),
        .din_o  (din_o),
        .busy_o (sh_busy),
        .ack_o  (sh_ack)
    );

    // Integrity error: device init active while done still inactive
    assign crc_err = !init_n_s && !done_s;

    // Byte intake is offered only while waiting for the next byte
    assign byte_ready_o = (state_q == LD_FETCH) && (remain_q != '0) && !crc_err;
    assign sh_load      = byte_ready_o && byte_valid_i;

    // Select what the bit engine does in each phase
    always_comb begin
        case (state_q)
            LD_FETCH, LD_SHIFT: sh_mode = SH_BYTES;
            LD_TRAIL:           sh_mode = SH_TRAIL;
            default:            sh_mode = SH_OFF;
        endcase
    end

    // Phase sequencing and result selection
    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        status_d = status_q;
        finish_d = 1'b0;
        prog_n_d = prog_n_q;
        case (state_q)
            LD_IDLE: begin
                if (start_i) begin
                    state_d  = LD_PROG;
                    remain_d = nbytes_i;
                    status_d = RES_NONE;
                    prog_n_d = 1'b0;
                end
            end
            LD_PROG: begin
                if (!init_n_s) begin
                    state_d  = LD_REL;
                    prog_n_d = 1'b1;
                end else if (tmo) begin
                    state_d  = LD_IDLE;
                    prog_n_d = 1'b1;
                    finish_d = 1'b1;
                    status_d = RES_INIT_LO_TMO;
                end
            end
            LD_REL: begin
                if (init_n_s) begin
                    state_d = LD_FETCH;
                end else if (tmo) begin
                    state_d  = LD_IDLE;
                    finish_d = 1'b1;
                    status_d = RES_INIT_HI_TMO;
                end
            end
            LD_FETCH: begin
                if (remain_q == '0) begin
                    state_d = LD_TRAIL;
                end else if (crc_err) begin
                    state_d  = LD_IDLE;
                    finish_d = 1'b1;
                    status_d = RES_CRC;
                end else if (byte_valid_i) begin
                    state_d  = LD_SHIFT;
                    remain_d = remain_q - 1'b1;
                end
            end
            LD_SHIFT: begin
                if (sh_ack) begin
                    state_d = LD_FETCH;
                end
            end
            LD_TRAIL: begin
                if (done_s) begin
                    state_d  = LD_IDLE;
                    finish_d = 1'b1;
                    status_d = RES_OK;
                end else if (tmo) begin
                    state_d  = LD_IDLE;
                    finish_d = 1'b1;
                    status_d = RES_DONE_TMO;
                end
            end
            default: begin
                state_d  = LD_IDLE;
                prog_n_d = 1'b1;
            end
        endcase
    end

    // Controller registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= LD_IDLE;
            remain_q <= '0;
            status_q <= RES_NONE;
            finish_q <= 1'b0;
            prog_n_q <= 1'b1;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
            status_q <= status_d;
            finish_q <= finish_d;
            prog_n_q <= prog_n_d;
        end
    end

    assign prog_n_o = prog_n_q;
    assign busy_o   = (state_q != LD_IDLE);
    assign finish_o = finish_q;
    assign status_o = status_q;

    // finish is a single-cycle pulse
    a_r9_finish_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |=> !finish_o);

    // finish arrives with busy already low and a real result code
    a_r9_finish_result: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |-> (!busy_o && (status_o != RES_NONE)));

    // no result is visible while a load runs
    a_r9_none_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (status_o == RES_NONE));

    // bytes are requested only with program released
    a_r2_ready_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> prog_n_o);

    // a new byte is requested only once the previous one has left
    a_r6_ready_not_shifting: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> !sh_busy);

    // a start during a load does not restart the program pulse
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && prog_n_o && start_i) |=> prog_n_o);

endmodule

// File: tb/tb_sercfg_loader.sv
module tb_sercfg_loader;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int TMO        = 300;
    localparam int CW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] nbytes_i = '0;
    logic [7:0]    byte_data = '0;
    logic          byte_valid = 1'b0;
    logic          byte_ready_o, prog_n_o, cclk_o, din_o, busy_o, finish_o;
    logic [2:0]    status_o;
    logic          init_n_dev, done_dev;

    int n_chk = 0;
    int n_fail = 0;

    // bench-side stimulus settings
    int dev_mode = 0;
    int exp_n = 0;
    int crc_at = 0;
    int trail_n = 1;
    logic [7:0] tx_mem [0:63];

    // device model state
    logic [7:0] rx_mem [0:63];
    int  rx_bits, trail_rises, pcnt, rcnt, cyc, last_rise, fed, fin_cnt;
    logic cclk_d, crc_fired, released, timing_bad, din_bad, ready_bad;

    sercfg_loader #(.DIV(DIV), .TIMEOUT(TMO), .CNT_W(CW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .nbytes_i     (nbytes_i),
        .byte_data_i  (byte_data),
        .byte_valid_i (byte_valid),
        .byte_ready_o (byte_ready_o),
        .prog_n_o     (prog_n_o),
        .cclk_o       (cclk_o),
        .din_o        (din_o),
        .init_n_i     (init_n_dev),
        .done_i       (done_dev),
        .busy_o       (busy_o),
        .finish_o     (finish_o),
        .status_o     (status_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reactive device model on the serial link
    always @(posedge clk) begin
        cyc    <= cyc + 1;
        cclk_d <= cclk_o;
        if (!rst_n) begin
            init_n_dev <= 1'b1; done_dev <= 1'b0; pcnt <= 0; rcnt <= 0;
            crc_fired <= 1'b0; released <= 1'b0; rx_bits <= 0; trail_rises <= 0;
            timing_bad <= 1'b0; din_bad <= 1'b0; last_rise <= 0;
        end else if (!prog_n_o) begin
            rx_bits <= 0; trail_rises <= 0; done_dev <= 1'b0; crc_fired <= 1'b0;
            released <= 1'b0; timing_bad <= 1'b0; din_bad <= 1'b0; rcnt <= 0;
            if (pcnt < 5) begin
                pcnt <= pcnt + 1;
                init_n_dev <= 1'b1;
            end else if (dev_mode != 1) begin
                init_n_dev <= 1'b0;
            end
        end else begin
            pcnt <= 0;
            if (!init_n_dev) begin
                if (rcnt < (crc_fired ? 30 : 5)) rcnt <= rcnt + 1;
                else if (dev_mode != 2) begin
                    init_n_dev <= 1'b1; released <= 1'b1; rcnt <= 0;
                end
            end
            if (cclk_o && !cclk_d) begin
                if (rx_bits < 8 * exp_n) begin
                    rx_mem[rx_bits/8] <= {rx_mem[rx_bits/8][6:0], din_o};
                    if ((rx_bits % 8 != 0) && (cyc - last_rise != 3 * DIV)) timing_bad <= 1'b1;
                    last_rise <= cyc;
                    rx_bits <= rx_bits + 1;
                    if (dev_mode == 3 && rx_bits + 1 == 8 * crc_at - 1) begin
                        init_n_dev <= 1'b0; crc_fired <= 1'b1; rcnt <= 0;
                    end
                end else begin
                    if (!din_o) din_bad <= 1'b1;
                    trail_rises <= trail_rises + 1;
                    if (trail_rises + 1 >= trail_n && dev_mode != 4) done_dev <= 1'b1;
                end
            end
        end
    end

    // Byte source bookkeeping and port monitors
    always @(posedge clk) begin
        if (!rst_n) begin
            fed <= 0; fin_cnt <= 0; ready_bad <= 1'b0;
        end else begin
            if (start_i && !busy_o) fed <= 0;
            else if (byte_valid && byte_ready_o) fed <= fed + 1;
            if (finish_o) fin_cnt <= fin_cnt + 1;
            if (byte_ready_o && (!prog_n_o || !released)) ready_bad <= 1'b1;
        end
    end

    // Byte source with random valid gaps
    always @(negedge clk) begin
        byte_valid <= (fed < exp_n) && ($urandom % 4 != 0);
        byte_data  <= tx_mem[fed % 64];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int mode);
        case (mode)
            1: return 1;
            2: return 2;
            3: return 3;
            4: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_bytes(input int mode, input int n, input int k);
        if (mode == 1 || mode == 2) return 0;
        if (mode == 3) return k;
        return n;
    endfunction

    function automatic string code_req(input int mode);
        case (mode)
            1: return "R3 init-low timeout status";
            2: return "R4 init-high timeout status";
            3: return "R7 integrity error status";
            4: return "R8 done timeout status";
            default: return "R8 success status";
        endcase
    endfunction

    task automatic run_one(input int n, input int mode, input int k, input int trl, input bit mid_start);
        int t;
        int fins;
        int eb;
        int bad;
        dev_mode = mode; exp_n = n; crc_at = k; trail_n = trl;
        for (int i = 0; i < 64; i++) tx_mem[i] = 8'($urandom);
        fins = fin_cnt;
        @(negedge clk);
        start_i = 1'b1; nbytes_i = CW'(n);
        @(negedge clk);
        start_i = 1'b0; nbytes_i = CW'(n + 7);   // R6: later change must not matter
        check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
        @(negedge clk);
        check(prog_n_o == 1'b0, "R2 program asserted", prog_n_o, 0);
        t = 2;
        while (!finish_o && t < 20000) begin
            if (mid_start && t == 40) begin
                start_i = 1'b1; nbytes_i = CW'(n + 3);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            t++;
        end
        start_i = 1'b0;
        check(finish_o == 1'b1, "R9 finish reached", t, 0);
        check(busy_o == 1'b0, "R9 busy low at finish", busy_o, 0);
        check(int'(status_o) == exp_code(mode), code_req(mode), status_o, exp_code(mode));
        eb = exp_bytes(mode, n, k);
        check(fed == eb, mid_start ? "R10 bytes accepted with start while busy" : "R6 bytes accepted", fed, eb);
        check(rx_bits == 8 * eb, "R5 bits clocked", rx_bits, 8 * eb);
        bad = 0;
        for (int i = 0; i < eb; i++) if (rx_mem[i] != tx_mem[i]) bad++;
        check(bad == 0, "R5 bytes received MSB first", bad, 0);
        check(timing_bad == 1'b0, "R5 bit spacing 3*DIV", timing_bad, 0);
        check(ready_bad == 1'b0, "R2 no request before init released", ready_bad, 0);
        if (mode == 0) check(din_bad == 1'b0, "R8 din high on trailing clocks", din_bad, 0);
        if (mode == 1 || mode == 2 || mode == 4)
            check(t >= TMO, "R3 R4 R8 timeout not early", t, TMO);
        @(negedge clk);
        @(negedge clk);
        check(cclk_o == 1'b0 && prog_n_o == 1'b1, "R7 link quiet after end", cclk_o, 0);
        check(int'(status_o) == exp_code(mode), "R9 result held", status_o, exp_code(mode));
        check(fin_cnt == fins + 1, "R9 single finish per load", fin_cnt - fins, 1);
        dev_mode = 0;
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) rx_mem[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b0, "R1 busy reset", busy_o, 0);
        check(prog_n_o == 1'b1, "R1 program reset", prog_n_o, 1);
        check(cclk_o == 1'b0, "R1 clock reset", cclk_o, 0);
        check(din_o == 1'b1, "R1 data reset", din_o, 1);
        check(byte_ready_o == 1'b0, "R1 ready reset", byte_ready_o, 0);
        check(finish_o == 1'b0, "R1 finish reset", finish_o, 0);
        check(status_o == 3'd7, "R1 status reset", status_o, 7);

        run_one(3, 0, 0, 3, 1'b0);   // plain load
        run_one(0, 0, 0, 2, 1'b0);   // R6 zero-length load
        run_one(4, 0, 0, 4, 1'b1);   // R10 start while busy
        run_one(2, 1, 0, 1, 1'b0);   // R3 init never goes low
        run_one(2, 2, 0, 1, 1'b0);   // R4 init stuck low
        run_one(5, 3, 2, 1, 1'b0);   // R7 integrity error before third byte
        run_one(2, 4, 0, 1, 1'b0);   // R8 done never rises
        run_one(1, 0, 0, 1, 1'b0);   // single byte, done after one clock
        for (int r = 0; r < 8; r++)
            run_one(1 + int'($urandom % 10), 0, 0, 1 + int'($urandom % 8), 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule